// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block judges every memory access of a core against a bank of protection entries and returns one verdict: allow or deny. An access is an address, an access kind (read, write or execute) and a privilege level (machine or user). Each entry has an 8-bit configuration byte and a 32-bit address register. The configuration byte picks one of four address-match modes and carries three permission bits and a lock bit. The address registers hold byte addresses divided by four.

The entries are loaded through a small write port. Configuration bytes travel four to a 32-bit word, and a security word carries the rule-lock bypass and the machine whitelist policy. The machine whitelist policy is on from reset and stays on. Under that policy a machine access that hits no entry is refused. An unlocked entry restricts only user code, while a locked entry restricts machine code as well. Locked entries refuse further writes unless the bypass is set.

The verdict comes from a three-state result machine. `ST_IDLE` means no result. `ST_GRANT` means allow and `ST_DENY` means deny. In every state, a request with `chk_valid` high moves the machine to `ST_GRANT` or `ST_DENY` according to the verdict, and a cycle without a request moves it to `ST_IDLE`. Reset enters `ST_IDLE`.

Top module: `pmp_guard`

## Requirements
- R1: A request sampled with `chk_valid` high gives `res_valid`=1 and its verdict on `res_allow` at the next clock edge. A cycle without a request gives `res_valid`=0 and `res_allow`=0 at the next edge. After reset both are 0.
- R2: With `wr_kind`=0, `wr_idx` selects configuration word w. Bits [8k+7:8k] of `wr_data` become the byte of entry 4w+k. The byte fields are: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 match mode (0 off, 1 TOR, 2 NA4, 3 NAPOT) and bit 7 lock. Bits 6:5 are stored as zero and have no effect. With `wr_kind`=1, `wr_idx` selects the address register that takes `wr_data`.
- R3: A TOR entry i matches word addresses from the address register of entry i-1 (inclusive) up to its own address register (exclusive). Entry 0 uses 0 as its lower bound.
- R4: An NA4 entry matches only the 4-byte word whose byte address divided by four equals its address register.
- R5: For an NAPOT entry, t is the number of trailing ones in its address register. The entry matches a naturally aligned region of 2^(t+1) words that contains the register value. An all-ones register matches every address.
- R6: An entry in mode off never matches. When several entries match, the one with the lowest index alone decides the verdict.
- R7: When an unlocked entry decides, a machine access is allowed. A user access is allowed only if the entry's bit for the access kind is set.
- R8: When a locked entry decides, machine and user accesses alike are allowed only if the entry's bit for the access kind is set. A lock with no permission bits refuses everything.
- R9: An access that matches no entry is denied if it comes from user mode. It is also denied if it comes from machine mode while the whitelist policy is on.
- R10: With `wr_kind`=2, `wr_data` bit 2 sets the rule-lock bypass. Bit 1 can set the whitelist policy but never clear it; the policy resets to on. Machine lockdown (bit 0) is held at zero.
- R11: While the bypass is clear, writes to a locked entry's configuration byte or address register have no effect. The address register of entry i-1 is also protected while entry i is locked in TOR mode. With the bypass set, these writes take effect.
- R12: `chk_kind` encodes read=0, write=1 and execute=2. The code 3 is always denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | 0 config word, 1 address register, 2 security word, 3 no effect |
| wr_idx | input | 4 | Word or entry index of the write |
| wr_data | input | 32 | Write data |
| chk_valid | input | 1 | Access request present |
| chk_addr | input | 32 | Byte address of the access |
| chk_kind | input | 2 | 0 read, 1 write, 2 execute, 3 invalid |
| chk_user | input | 1 | 1 user mode, 0 machine mode |
| res_valid | output | 1 | Verdict present |
| res_allow | output | 1 | 1 allow, 0 deny |

## Verification
The verdict passes through one register, the result state. It is therefore due at the first clock edge after the request is sampled. The bench drives each request on a falling edge and reads `res_valid`/`res_allow` on the next falling edge. A register write takes effect at the edge where it is sampled. The bench therefore finishes each write one full cycle before issuing the requests that depend on it. An equivalent rule applies to reset, which is released a full cycle ahead of the first request.

// File: rtl/pmp_guard_pkg.sv
package pmp_guard_pkg;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_TOR   = 2'd1,
        MATCH_NA4   = 2'd2,
        MATCH_NAPOT = 2'd3
    } match_mode_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_BAD   = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        WK_CFG  = 2'd0,
        WK_ADDR = 2'd1,
        WK_SEC  = 2'd2,
        WK_NONE = 2'd3
    } wr_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_DENY  = 2'd2
    } res_state_e;

    // packed MSB first: lock is bit 7, r is bit 0
    typedef struct packed {
        logic        lock;
        logic [1:0]  rsvd;
        match_mode_e mode;
        logic        x;
        logic        w;
        logic        r;
    } entry_cfg_t;

endpackage

// File: rtl/pmp_guard_regs.sv
module pmp_guard_regs
    import pmp_guard_pkg::*;
#(
    parameter int N  = 16,
    parameter int AW = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               wr_kind,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [31:0]              wr_data,
    output entry_cfg_t [N-1:0]       cfg_q,
    output logic [N-1:0][AW-1:0]     addr_q,
    output logic                     rlb_q,
    output logic                     mmwp_q
);
    localparam int PER_WORD = 4;

    // security word: bypass is free, whitelist policy can only be set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rlb_q  <= 1'b0;
            mmwp_q <= 1'b1;
        end else if (wr_en && wr_kind == WK_SEC) begin
            rlb_q  <= wr_data[2];
            mmwp_q <= mmwp_q | wr_data[1];
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_entry
        entry_cfg_t        cfg_r;
        entry_cfg_t        cfg_new;
        logic [AW-1:0]     addr_r;
        logic              guard_tor;
        logic              cfg_frozen;
        logic              addr_frozen;

        if (i + 1 < N) begin : g_up
            assign guard_tor = cfg_q[i+1].lock && (cfg_q[i+1].mode == MATCH_TOR);
        end else begin : g_top
            assign guard_tor = 1'b0;
        end

        assign cfg_frozen  = cfg_r.lock && !rlb_q;
        assign addr_frozen = (cfg_r.lock || guard_tor) && !rlb_q;

        always_comb begin
            cfg_new      = entry_cfg_t'(wr_data[(i % PER_WORD)*8 +: 8]);
            cfg_new.rsvd = 2'b00;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_r  <= '0;
                addr_r <= '0;
            end else if (wr_en) begin
                if (wr_kind == WK_CFG && int'(wr_idx) == i / PER_WORD && !cfg_frozen)
                    cfg_r <= cfg_new;
                if (wr_kind == WK_ADDR && int'(wr_idx) == i && !addr_frozen)
                    addr_r <= wr_data[AW-1:0];
            end
        end

        assign cfg_q[i]  = cfg_r;
        assign addr_q[i] = addr_r;
    end

endmodule

// File: rtl/pmp_guard_match.sv
module pmp_guard_match
    import pmp_guard_pkg::*;
#(
    parameter int AW = 32
) (
    input  entry_cfg_t    cfg,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic [AW-1:0] word_addr,
    output logic          hit
);
    logic [AW-1:0] napot_ign;

    // ones over the trailing-ones run and the zero just above it
    assign napot_ign = hi ^ (hi + AW'(1));

    always_comb begin
        unique case (cfg.mode)
            MATCH_OFF:   hit = 1'b0;
            MATCH_TOR:   hit = (word_addr >= lo) && (word_addr < hi);
            MATCH_NA4:   hit = (word_addr == hi);
            MATCH_NAPOT: hit = ((word_addr ^ hi) & ~napot_ign) == '0;
            default:     hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmp_guard_decide.sv
module pmp_guard_decide
    import pmp_guard_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]       hit,
    input  entry_cfg_t [N-1:0] cfg,
    input  logic [1:0]         kind,
    input  logic               user,
    input  logic               mmwp,
    output logic               allow
);
    logic found;
    logic locked;
    logic perm;

    // scan downward so the lowest matching index is written last
    always_comb begin
        found  = 1'b0;
        locked = 1'b0;
        perm   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) begin
                found  = 1'b1;
                locked = cfg[i].lock;
                unique case (acc_kind_e'(kind))
                    ACC_READ:  perm = cfg[i].r;
                    ACC_WRITE: perm = cfg[i].w;
                    ACC_EXEC:  perm = cfg[i].x;
                    default:   perm = 1'b0;
                endcase
            end
        end

        if (acc_kind_e'(kind) == ACC_BAD)
            allow = 1'b0;
        else if (found)
            allow = (locked || user) ? perm : 1'b1;
        else
            allow = user ? 1'b0 : !mmwp;
    end

endmodule

// File: rtl/pmp_guard.sv
module pmp_guard
    import pmp_guard_pkg::*;
#(
    parameter int N  = 16,
    parameter int AW = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_kind,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic             chk_valid,
    input  logic [AW-1:0]    chk_addr,
    input  logic [1:0]       chk_kind,
    input  logic             chk_user,
    output logic             res_valid,
    output logic             res_allow
);
    entry_cfg_t [N-1:0]    cfg_q;
    logic [N-1:0][AW-1:0]  addr_q;
    logic                  rlb_q;
    logic                  mmwp_q;
    logic [N-1:0]          hit;
    logic [AW-1:0]         word_addr;
    logic                  verdict;
    res_state_e            state_q;
    res_state_e            state_d;

    assign word_addr = chk_addr >> 2;

    pmp_guard_regs #(.N(N), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_kind (wr_kind),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .cfg_q   (cfg_q),
        .addr_q  (addr_q),
        .rlb_q   (rlb_q),
        .mmwp_q  (mmwp_q)
    );

    for (genvar i = 0; i < N; i++) begin : g_match
        logic [AW-1:0] lo_bound;
        if (i == 0) begin : g_first
            assign lo_bound = '0;
        end else begin : g_rest
            assign lo_bound = addr_q[i-1];
        end
        pmp_guard_match #(.AW(AW)) u_match (
            .cfg       (cfg_q[i]),
            .lo        (lo_bound),
            .hi        (addr_q[i]),
            .word_addr (word_addr),
            .hit       (hit[i])
        );
    end

    pmp_guard_decide #(.N(N)) u_decide (
        .hit   (hit),
        .cfg   (cfg_q),
        .kind  (chk_kind),
        .user  (chk_user),
        .mmwp  (mmwp_q),
        .allow (verdict)
    );

    // result state machine
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_GRANT, ST_DENY: begin
                if (!chk_valid)   state_d = ST_IDLE;
                else if (verdict) state_d = ST_GRANT;
                else              state_d = ST_DENY;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_GRANT: begin res_valid = 1'b1; res_allow = 1'b1; end
            ST_DENY:  begin res_valid = 1'b1; res_allow = 1'b0; end
            default:  begin res_valid = 1'b0; res_allow = 1'b0; end
        endcase
    end

endmodule

// File: rtl/pmp_guard_chk.sv
module pmp_guard_chk
    import pmp_guard_pkg::*;
#(
    parameter int N  = 16,
    parameter int AW = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 chk_valid,
    input logic [1:0]           chk_kind,
    input logic                 res_valid,
    input logic                 res_allow,
    input entry_cfg_t [N-1:0]   cfg_q,
    input logic [N-1:0][AW-1:0] addr_q,
    input logic                 rlb_q,
    input logic                 mmwp_q
);
    assert_valid_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> res_valid);

    assert_idle_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> (!res_valid && !res_allow));

    assert_bad_kind_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_kind == 2'd3) |=> !res_allow);

    assert_policy_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mmwp_q |=> mmwp_q);

    for (genvar i = 0; i < N; i++) begin : g_ent
        assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_q[i].rsvd == 2'b00);

        assert_cfg_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[i].lock && !rlb_q) |=> $stable(cfg_q[i]));

        assert_addr_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[i].lock && !rlb_q) |=> $stable(addr_q[i]));
    end

endmodule

bind pmp_guard pmp_guard_chk #(.N(N), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_valid (chk_valid),
    .chk_kind  (chk_kind),
    .res_valid (res_valid),
    .res_allow (res_allow),
    .cfg_q     (cfg_q),
    .addr_q    (addr_q),
    .rlb_q     (rlb_q),
    .mmwp_q    (mmwp_q)
);

// File: tb/pmp_guard_tb.sv
module pmp_guard_tb;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = 2'd3;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        chk_valid = 1'b0;
    logic [31:0] chk_addr = '0;
    logic [1:0]  chk_kind = '0;
    logic        chk_user = 1'b0;
    logic        res_valid;
    logic        res_allow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  m_cfg  [N];
    logic [31:0] m_addr [N];
    bit          m_rlb;
    bit          m_mmwp;

    always #2.5 clk = ~clk;

    pmp_guard u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .chk_valid(chk_valid),
        .chk_addr(chk_addr), .chk_kind(chk_kind), .chk_user(chk_user),
        .res_valid(res_valid), .res_allow(res_allow)
    );

    task automatic check(input bit got, input bit exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // reference model built from the requirements
    function automatic bit model(input logic [31:0] a, input int k, input bit u,
                                 output string tag);
        longint wa = longint'(a >> 2);
        string mt;
        if (k == 3) begin tag = "R12"; return 1'b0; end
        for (int i = 0; i < N; i++) begin
            int  md = int'(m_cfg[i][4:3]);
            bit  h = 1'b0;
            if (md == 1) begin
                longint lo = (i == 0) ? 0 : longint'(m_addr[i-1]);
                h = (wa >= lo) && (wa < longint'(m_addr[i]));
                mt = "R3";
            end else if (md == 2) begin
                h = (wa == longint'(m_addr[i]));
                mt = "R4";
            end else if (md == 3) begin
                int t = 0;
                while (t < 32 && m_addr[i][t]) t++;
                if (t >= 32) h = 1'b1;
                else begin
                    longint sz = longint'(1) << (t + 1);
                    longint base = longint'(m_addr[i]) / sz * sz;
                    h = (wa >= base) && (wa < base + sz);
                end
                mt = "R5";
            end
            if (h) begin
                bit p = m_cfg[i][k];
                if (m_cfg[i][7]) begin tag = {"R8 via ", mt, " R6"}; return p; end
                tag = {"R7 via ", mt, " R6"};
                return u ? p : 1'b1;
            end
        end
        tag = "R9";
        return u ? 1'b0 : !m_mmwp;
    endfunction

    task automatic wr(input int kind, input int idx, input logic [31:0] d);
        if (kind == 0) begin
            for (int k = 0; k < 4; k++) begin
                int e = idx * 4 + k;
                if (!(m_cfg[e][7] && !m_rlb)) m_cfg[e] = d[k*8 +: 8] & 8'h9F;
            end
        end else if (kind == 1) begin
            bit lk = m_cfg[idx][7];
            if (idx < N - 1 && m_cfg[idx+1][7] && m_cfg[idx+1][4:3] == 2'd1) lk = 1'b1;
            if (!(lk && !m_rlb)) m_addr[idx] = d;
        end else if (kind == 2) begin
            m_rlb  = d[2];
            m_mmwp = m_mmwp | d[1];
        end
        @(negedge clk);
        wr_en = 1'b1; wr_kind = 2'(kind); wr_idx = 4'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_kind = 2'd3;
    endtask

    task automatic access(input logic [31:0] a, input int k, input bit u,
                          input string extra);
        string tag;
        bit exp;
        exp = model(a, k, u, tag);
        @(negedge clk);
        chk_valid = 1'b1; chk_addr = a; chk_kind = 2'(k); chk_user = u;
        @(negedge clk);
        chk_valid = 1'b0;
        check(res_valid, 1'b1, "R1 valid");
        check(res_allow, exp, {tag, extra});
    endtask

    task automatic sweep(input int hi_byte);
        for (int a = 0; a < hi_byte; a += 4)
            for (int k = 0; k < 4; k++)
                for (int u = 0; u < 2; u++)
                    access(32'(a | ((a >> 2) & 3)), k, bit'(u), "");
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin m_cfg[i] = '0; m_addr[i] = '0; end
        m_rlb = 1'b0; m_mmwp = 1'b1;
        repeat (3) @(negedge clk);
        check(res_valid, 1'b0, "R1 reset valid");
        check(res_allow, 1'b0, "R1 reset allow");
        rst_n = 1'b1;
        @(negedge clk);
        access(32'h100, 0, 1'b0, " machine empty");
        access(32'h100, 0, 1'b1, " user empty");
        @(negedge clk);
        check(res_valid, 1'b0, "R1 idle after request");

        // addresses first, then configuration words (locks freeze later writes)
        wr(1, 0, 32'h10);  wr(1, 1, 32'h20);  wr(1, 2, 32'h47);  wr(1, 3, 32'h7C);
        wr(1, 4, 32'h5F);  wr(1, 5, 32'h80);  wr(1, 6, 32'h88);  wr(1, 7, 32'h8C);
        wr(0, 0, 32'hF0_99_93_0D);   // e3 carries reserved bits 6:5 (R2)
        wr(0, 1, 32'h12_8D_00_1F);
        sweep(32'h260);

        // R11: writes to locked entries and the TOR lower bound are ignored
        wr(0, 0, 32'h0);
        wr(1, 1, 32'h0);
        wr(1, 5, 32'h0);
        access(32'h80,  0, 1'b0, " R11 locked cfg/addr kept");
        access(32'h80,  2, 1'b0, " R11 locked exec");
        access(32'h210, 2, 1'b0, " R11 TOR base kept");
        sweep(32'h260);

        // R10: bypass on, try to clear the whitelist policy
        wr(2, 0, 32'h4);
        access(32'h300, 0, 1'b0, " R10 policy stays on");
        wr(0, 0, 32'h0);
        wr(0, 1, 32'h0_8D_00_00);
        wr(1, 5, 32'h81);
        wr(1, 2, 32'hFFFF_FFFF);
        wr(0, 0, 32'h0_1B_00_00);      // entry 2 NAPOT all-ones, read+write, unlocked
        access(32'h204, 0, 1'b1, " R11 bypass write");
        sweep(32'h260);
        access(32'hFFFF_FFF0, 1, 1'b1, " R5 all-ones");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule